// File: doc/BRIEF.md
# Step Pulse and Direction Generator

This block turns a signed step-rate command for one axis into the two signals a stepper amplifier expects: a step line and a direction line. The step line is a clean square wave whose frequency is set by the rate word, read as the increment of a phase accumulator. It works with full-step, half-step or microstepping drives. The sign of the rate word selects the direction of travel. The block also keeps a signed count of the steps it has issued, and it raises an at-rest flag that an amplifier can use to switch to holding torque.

A trajectory generator upstream writes a new rate on any cycle. The block applies the new rate at once, with two exceptions. A change of direction waits until the direction line can switch safely. A stop lets the half-cycle in progress finish, so the step line never shows a short glitch. A step is the high-to-low transition of the step line.

Top module: `step_pulse_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `step_o` is 1, `dir_o` is 1, `at_rest_o` is 1 and `step_count_o` is 0.
- R2: For a constant rate of magnitude M, `step_o` is a 50% square wave. When 2^31 is a multiple of M, each half period lasts exactly 2^31/M clock cycles. For rate 0x0800_0000 this is 16 cycles high and 16 cycles low.
- R3: `dir_o` is 1 for a positive rate and 0 for a negative rate. It changes only in a cycle where `step_o` was high in the previous cycle and is still high.
- R4: `step_count_o` changes only in the cycle where `step_o` falls. At that point it goes up by one if `dir_o` is 1 and down by one if `dir_o` is 0.
- R5: The rate magnitude is limited to floor(MAX_STEP_HZ·2^32/CLK_HZ), which is 257698037 with the default parameters (1.5 M steps/s at 25 MHz). No half period is then shorter than 8 cycles, and a full-scale rate gives 60±1 steps per 1000 cycles.
- R6: When the rate is zero, a low half-cycle in progress runs to its end. `step_o` then stays high, `at_rest_o` goes to 1 and the count stops changing. `at_rest_o` is 0 while steps are being issued.
- R7: With `en_i` at 0, the block behaves exactly as with a zero rate, whatever the value of `rate_i`.
- R8: If the sign of the rate reverses while `step_o` is low, the low half ends with `dir_o` unchanged. `dir_o` switches one cycle after the next rise, and that high half is one cycle longer (17 cycles at rate magnitude 0x0800_0000). The next fall counts in the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enables step generation |
| rate_i | input | ACC_W | Signed rate; magnitude is the accumulator increment per cycle |
| step_o | output | 1 | Step square wave; a step is its falling edge |
| dir_o | output | 1 | 1 = positive travel, 0 = negative travel |
| at_rest_o | output | 1 | 1 while the axis is parked |
| step_count_o | output | CNT_W | Signed count of issued steps |

## Verification
A corrupted accumulator or a wrong increment shows up within one half period as a run length on `step_o` that differs from the value predicted from the rate. A bad clamp shows up as more than 61 falls in a 1000-cycle window at full scale. A direction register that updates at the wrong time shows up as an edge on `dir_o` next to a low sample of `step_o`, or as a high half that is not one cycle longer after a reversal. An error in the counter shows up at the next fall, as a count that no longer matches the number of falls the bench has seen, signed by `dir_o`.

// File: rtl/spg_pkg.sv
package spg_pkg;
  typedef enum logic {
    SPG_DIR_NEG = 1'b0,
    SPG_DIR_POS = 1'b1
  } spg_dir_e;
endpackage

// File: rtl/spg_rate_clamp.sv
module spg_rate_clamp #(
  parameter int ACC_W       = 32,
  parameter int CLK_HZ      = 25_000_000,
  parameter int MAX_STEP_HZ = 1_500_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [ACC_W-1:0]  rate_i,
  output logic              active_o,
  output spg_pkg::spg_dir_e tgt_dir_o,
  output logic [ACC_W-1:0]  inc_o
);
  localparam longint unsigned LIMIT_L =
    (longint'(MAX_STEP_HZ) << ACC_W) / longint'(CLK_HZ);
  localparam logic [ACC_W-1:0] LIMIT = LIMIT_L[ACC_W-1:0];

  logic             is_neg;
  logic [ACC_W-1:0] mag;

  always_comb begin
    is_neg    = rate_i[ACC_W-1];
    mag       = is_neg ? (~rate_i + 1'b1) : rate_i;
    inc_o     = (mag > LIMIT) ? LIMIT : mag;
    active_o  = en_i && (mag != '0);
    tgt_dir_o = is_neg ? spg_pkg::SPG_DIR_NEG : spg_pkg::SPG_DIR_POS;
  end

  assert_clamp_R5: assert property (@(posedge clk) disable iff (rst)
    inc_o <= LIMIT);
endmodule

// File: rtl/spg_phase_acc.sv
module spg_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  spg_pkg::spg_dir_e tgt_dir_i,
  input  logic [ACC_W-1:0]  inc_i,
  output logic              pulse_o,
  output spg_pkg::spg_dir_e dir_o,
  output logic              at_rest_o,
  output logic              fall_o
);
  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0]  acc_q, acc_n;
  logic [ACC_W-1:0]  hold_q;
  spg_pkg::spg_dir_e dir_n;
  logic              in_high;

  always_comb begin
    in_high = !acc_q[MSB];
    acc_n   = acc_q;
    dir_n   = dir_o;
    if (active_i) begin
      if (in_high && (dir_o != tgt_dir_i)) begin
        dir_n = tgt_dir_i;
      end else begin
        acc_n = acc_q + inc_i;
      end
    end else if (!in_high) begin
      acc_n = acc_q + hold_q;
    end else begin
      acc_n = '0;
    end
    fall_o = in_high && acc_n[MSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      hold_q    <= '0;
      dir_o     <= spg_pkg::SPG_DIR_POS;
      pulse_o   <= 1'b1;
      at_rest_o <= 1'b1;
    end else begin
      acc_q     <= acc_n;
      dir_o     <= dir_n;
      pulse_o   <= !acc_n[MSB];
      at_rest_o <= !active_i && !acc_n[MSB];
      if (active_i) hold_q <= inc_i;
    end
  end

  assert_dir_high_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_o) |-> (pulse_o && $past(pulse_o)));
  assert_rest_high_R6: assert property (@(posedge clk) disable iff (rst)
    at_rest_o |-> pulse_o);
  assert_min_half_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> $past(pulse_o, 2));
endmodule

// File: rtl/spg_step_counter.sv
module spg_step_counter #(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_i,
  input  spg_pkg::spg_dir_e dir_i,
  output logic [CNT_W-1:0]  count_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
    end else if (fall_i) begin
      if (dir_i == spg_pkg::SPG_DIR_POS) count_o <= count_o + 1'b1;
      else                               count_o <= count_o - 1'b1;
    end
  end
endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen #(
  parameter int ACC_W       = 32,
  parameter int CNT_W       = 32,
  parameter int CLK_HZ      = 25_000_000,
  parameter int MAX_STEP_HZ = 1_500_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [ACC_W-1:0] rate_i,
  output logic             step_o,
  output logic             dir_o,
  output logic             at_rest_o,
  output logic [CNT_W-1:0] step_count_o
);
  logic              active;
  logic              fall;
  logic [ACC_W-1:0]  inc;
  spg_pkg::spg_dir_e tgt_dir;
  spg_pkg::spg_dir_e dir_e;

  spg_rate_clamp #(
    .ACC_W(ACC_W), .CLK_HZ(CLK_HZ), .MAX_STEP_HZ(MAX_STEP_HZ)
  ) u_clamp (
    .clk(clk), .rst(rst), .en_i(en_i), .rate_i(rate_i),
    .active_o(active), .tgt_dir_o(tgt_dir), .inc_o(inc)
  );

  spg_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .active_i(active), .tgt_dir_i(tgt_dir),
    .inc_i(inc), .pulse_o(step_o), .dir_o(dir_e),
    .at_rest_o(at_rest_o), .fall_o(fall)
  );

  spg_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .fall_i(fall), .dir_i(dir_e),
    .count_o(step_count_o)
  );

  assign dir_o = (dir_e == spg_pkg::SPG_DIR_POS);

  assert_count_up_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(step_o) && dir_o) |-> (step_count_o == $past(step_count_o) + 1'b1));
  assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(step_o) && !dir_o) |-> (step_count_o == $past(step_count_o) - 1'b1));
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$fell(step_o) |-> $stable(step_count_o));
endmodule

// File: tb/step_pulse_gen_test.sv
module step_pulse_gen_test;
  localparam int PERIOD = 10;
  localparam int ACC_W  = 32;
  localparam int CNT_W  = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en_i = 1'b0;
  logic [ACC_W-1:0] rate_i = '0;
  logic             step_o, dir_o, at_rest_o;
  logic [CNT_W-1:0] step_count_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic prev_pulse, prev_dir;
  int   run_len, last_run, falls;
  bit   fell_now, rose_now;

  always #(PERIOD/2) clk = ~clk;

  step_pulse_gen uut (
    .clk(clk), .rst(rst), .en_i(en_i), .rate_i(rate_i),
    .step_o(step_o), .dir_o(dir_o), .at_rest_o(at_rest_o),
    .step_count_o(step_count_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint cnt();
    return longint'($signed(step_count_o));
  endfunction

  task automatic tick();
    @(negedge clk);
    fell_now = prev_pulse && !step_o;
    rose_now = !prev_pulse && step_o;
    if (dir_o !== prev_dir)
      check(prev_pulse && step_o, "R3 dir edge beside low step", {63'd0, prev_pulse & step_o}, 1);
    if (fell_now) falls++;
    if (step_o === prev_pulse) run_len++;
    else begin
      last_run = run_len;
      run_len  = 1;
    end
    prev_pulse = step_o;
    prev_dir   = dir_o;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(step_o == 1 && dir_o == 1 && at_rest_o == 1, "R1 outputs in reset",
          {61'd0, step_o, dir_o, at_rest_o}, 7);
    rst = 1'b0;
    prev_pulse = step_o; prev_dir = dir_o; run_len = 1; last_run = 0; falls = 0;
    tick();
    check(step_o == 1 && at_rest_o == 1, "R1 step/at_rest after reset", {62'd0, step_o, at_rest_o}, 3);
    check(cnt() == 0, "R1 count after reset", cnt(), 0);
  endtask

  task automatic t_square();
    longint c0;
    int f0, seen, bad;
    c0 = cnt(); f0 = falls; seen = 0; bad = 0;
    rate_i = 32'h0800_0000; en_i = 1'b1;
    while (seen < 8) begin
      tick();
      if (fell_now || rose_now) begin
        seen++;
        if (seen > 1 && last_run != 16) begin
          bad++;
          check(0, "R2 half period", last_run, 16);
        end
      end
    end
    check(bad == 0, "R2 all half periods 16", bad, 0);
    check(dir_o == 1, "R3 dir high for positive rate", dir_o, 1);
    check(at_rest_o == 0, "R6 at_rest low while moving", at_rest_o, 0);
    check(cnt() - c0 == longint'(falls - f0), "R4 count tracks falls up", cnt() - c0, falls - f0);
  endtask

  task automatic t_reverse();
    longint c0;
    bit held;
    int n;
    fell_now = 0;
    while (!fell_now) tick();
    c0 = cnt();
    rate_i = -32'sh0800_0000;
    held = 1;
    tick();
    while (!step_o) begin
      if (dir_o != 1) held = 0;
      tick();
    end
    check(held, "R8 dir held during low half", {63'd0, held}, 1);
    n = 0;
    while (dir_o && n < 5) begin tick(); n++; end
    check(n == 1, "R8 dir switch delay after rise", n, 1);
    fell_now = 0;
    while (!fell_now) tick();
    check(last_run == 17, "R8 stretched high half", last_run, 17);
    check(cnt() == c0 - 1, "R8 first new fall counts down", cnt(), c0 - 1);
  endtask

  task automatic t_negative();
    longint c0;
    int f0;
    c0 = cnt(); f0 = falls;
    repeat (200) tick();
    check(dir_o == 0, "R3 dir low for negative rate", dir_o, 0);
    check(falls - f0 >= 6, "R2 falls at negative rate", falls - f0, 6);
    check(cnt() - c0 == -longint'(falls - f0), "R4 count tracks falls down", cnt() - c0, -(falls - f0));
  endtask

  task automatic t_stop();
    longint c0;
    int n, f0;
    bit stayed;
    while (step_o) tick();
    check(at_rest_o == 0, "R6 at_rest low before stop", at_rest_o, 0);
    rate_i = '0;
    n = 0;
    while (!step_o && n < 40) begin tick(); n++; end
    check(step_o == 1, "R6 step returns high", step_o, 1);
    check(at_rest_o == 1, "R6 at_rest at park", at_rest_o, 1);
    c0 = cnt(); f0 = falls; stayed = 1;
    repeat (50) begin tick(); if (!step_o || !at_rest_o) stayed = 0; end
    check(stayed, "R6 parked high and at rest", {63'd0, stayed}, 1);
    check(cnt() == c0 && falls == f0, "R6 count frozen", cnt(), c0);
  endtask

  task automatic t_enable();
    longint c0;
    bit stayed;
    rate_i = 32'h0800_0000; en_i = 1'b1;
    repeat (45) tick();
    en_i = 1'b0;
    repeat (40) tick();
    check(step_o == 1 && at_rest_o == 1, "R7 disabled parks", {62'd0, step_o, at_rest_o}, 3);
    c0 = cnt(); stayed = 1;
    repeat (30) begin tick(); if (!step_o || !at_rest_o) stayed = 0; end
    check(stayed && cnt() == c0, "R7 rate ignored while disabled", cnt(), c0);
    en_i = 1'b1;
  endtask

  task automatic t_clamp();
    int f0, minrun, seen;
    longint c0;
    rate_i = 32'h7FFF_FFFF; en_i = 1'b1;
    repeat (40) tick();
    f0 = falls; c0 = cnt(); minrun = 1000; seen = 0;
    repeat (1000) begin
      tick();
      if (fell_now || rose_now) begin
        seen++;
        if (seen > 1 && last_run < minrun) minrun = last_run;
      end
    end
    check(falls - f0 >= 59 && falls - f0 <= 61, "R5 steps per 1000 cycles", falls - f0, 60);
    check(minrun >= 8, "R5 shortest half period", minrun, 8);
    check(cnt() - c0 == longint'(falls - f0), "R4 count at full scale", cnt() - c0, falls - f0);
  endtask

  initial begin
    t_reset();
    t_square();
    t_reverse();
    t_negative();
    t_stop();
    t_enable();
    t_clamp();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule